// File: doc/BRIEF.md
# Cache Flush Sequencer with Snoop Service

This block owns the state bits of a small write-back cache and sequences a full flush of it. A flush begins on a pulse of either the external flush pin or the write-back-and-invalidate command. The block then visits the lines in ascending index order. Each modified line is handed to a separate burst bus engine as a copy-back request. Every other line is invalidated on the spot, at one line per cycle. When the walk has covered every line, the block issues two flush-acknowledge special cycles through the same engine, first and then second.

Snoops keep being served throughout, just as when no flush is running. A snoop that finds a modified line gets a priority write-back, issued before the walk takes its next step. The walk index sits in a register, so the walk then picks up at the line where it paused. A snoop aimed at the line whose copy-back is already on the bus is covered by that transfer and adds no second write. Outside a flush, a cache controller loads line states through an update port, and a probe port reads any line's state.

Top module: `cache_flush_seq`

## Requirements
- R1: A one-cycle pulse on `flush_pin_i` or `wbinv_cmd_i` while `busy_o` is low starts a flush. `busy_o` is high from the next cycle until the cycle after the second acknowledge completes.
- R2: The walk visits lines from index 0 upward. A modified line raises `wb_req_o` with `wb_snoop_o`=0 and its index on `wb_index_o`, holding all three stable until `wb_done_i`; the line then becomes invalid. A clean or invalid line becomes invalid with no bus request, at one line per cycle.
- R3: `snp_ready_o` is high except while a snoop write-back is pending or in flight. An accepted snoop (`snp_valid_i` and `snp_ready_o`) that hits a modified line, other than the one in flight, produces a write-back with `wb_snoop_o`=1 before the walk advances further. That line then becomes clean if `snp_inval_i`=0, or invalid if `snp_inval_i`=1. `snp_hitm_o` is high in the cycle of acceptance of any snoop that hits a modified line.
- R4: After a snoop write-back, or a cycle in which a snoop is accepted, the walk continues at its saved index. It does not restart at line 0.
- R5: A snoop that hits the line whose walk copy-back is in flight produces no extra write of that line.
- R6: A snoop that hits a clean or invalid line produces no bus request. With `snp_inval_i`=1 the line becomes invalid; otherwise its state is unchanged.
- R7: After the last line, `ack_req_o` is raised with `ack_second_o`=0 until `ack_done_i`, then with `ack_second_o`=1 until `ack_done_i`; the flush then ends.
- R8: Flush requests are ignored while `busy_o` is high, and so are writes on the update port.
- R9: Each line that was modified when a flush started is written on the bus exactly once during that flush, and every line is invalid when `busy_o` falls.
- R10: After reset all lines are invalid, `busy_o`, `wb_req_o` and `ack_req_o` are low, and `snp_ready_o` is high.
- R11: Line state encoding is 0 invalid, 1 clean and 2 modified. While `busy_o` is low, `upd_valid_i` writes `upd_state_i` into line `upd_index_i` at the clock edge. `prb_state_o` shows the state of line `prb_index_i` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush_pin_i | input | 1 | External flush request pulse |
| wbinv_cmd_i | input | 1 | Write-back-and-invalidate command pulse |
| upd_valid_i | input | 1 | Line state update strobe |
| upd_index_i | input | IW | Line index to update |
| upd_state_i | input | 2 | New line state (0 I, 1 C, 2 M) |
| snp_valid_i | input | 1 | Snoop request |
| snp_index_i | input | IW | Snooped line index |
| snp_inval_i | input | 1 | Snoop also invalidates the line |
| snp_ready_o | output | 1 | Snoop can be accepted this cycle |
| snp_hitm_o | output | 1 | Accepted snoop hit a modified line |
| wb_req_o | output | 1 | Write-back request to the burst engine |
| wb_index_o | output | IW | Line index of the write-back |
| wb_snoop_o | output | 1 | Write-back is a snoop priority write |
| wb_done_i | input | 1 | Burst engine finished the write-back |
| ack_req_o | output | 1 | Flush-acknowledge special cycle request |
| ack_second_o | output | 1 | 0 first acknowledge, 1 second acknowledge |
| ack_done_i | input | 1 | Special cycle completed |
| prb_index_i | input | IW | Probe line index |
| prb_state_o | output | 2 | State of the probed line |
| busy_o | output | 1 | Flush in progress |

## Verification
The bench builds the block with its default of eight lines. That keeps each walk short enough for random snoops to land at every walk index, during the final line and during the acknowledge phase, over many flushes. Random engine latencies of zero to three cycles let snoops arrive while a copy-back is in flight, so both the in-flight coverage case and the pending priority write-back case occur. A directed flush fixes the order of bus writes to show resumption at the saved index.

// File: rtl/cfs_pkg.sv
package cfs_pkg;
  typedef enum logic [1:0] {
    LS_INV = 2'd0,
    LS_CLN = 2'd1,
    LS_MOD = 2'd2
  } line_st_t;

  typedef enum logic [2:0] {
    F_IDLE, F_SCAN, F_CB, F_SWB, F_ACK1, F_ACK2
  } fsm_t;

  // state a line takes once its snoop write-back has finished
  function automatic line_st_t after_snoop(input logic inval);
    return inval ? LS_INV : LS_CLN;
  endfunction
endpackage

// File: rtl/cfs_line_array.sv
module cfs_line_array
  import cfs_pkg::*;
#(
  parameter int LINES = 8,
  parameter int IW    = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   walk_en,
  input  logic [IW-1:0]          walk_idx,
  input  logic                   sw_en,
  input  logic [IW-1:0]          sw_idx,
  input  line_st_t               sw_st,
  input  logic                   kill_en,
  input  logic [IW-1:0]          kill_idx,
  input  logic                   upd_en,
  input  logic [IW-1:0]          upd_idx,
  input  line_st_t               upd_st,
  output line_st_t [LINES-1:0]   lines_o
);
  generate
    for (genvar g = 0; g < LINES; g++) begin : g_line
      line_st_t q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                              q <= LS_INV;
        else if (walk_en && walk_idx == IW'(g))  q <= LS_INV;
        else if (sw_en   && sw_idx   == IW'(g))  q <= sw_st;
        else if (kill_en && kill_idx == IW'(g))  q <= LS_INV;
        else if (upd_en  && upd_idx  == IW'(g))  q <= upd_st;
      end
      assign lines_o[g] = q;
    end
  endgenerate
endmodule

// File: rtl/cfs_snoop.sv
module cfs_snoop
  import cfs_pkg::*;
#(
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          snp_valid_i,
  input  logic [IW-1:0] snp_index_i,
  input  logic          snp_inval_i,
  input  line_st_t      hit_st,
  input  logic          in_flight,
  input  logic          swb_active,
  input  logic          clr,
  output logic          ready,
  output logic          fire,
  output logic          hitm,
  output logic          kill_en,
  output logic          pend_q,
  output logic [IW-1:0] pidx_q,
  output logic          pinv_q
);
  logic set_pend;

  assign ready    = !pend_q && !swb_active;
  assign fire     = snp_valid_i && ready;
  assign hitm     = fire && hit_st == LS_MOD;
  assign set_pend = hitm && !in_flight;
  assign kill_en  = fire && hit_st != LS_MOD && snp_inval_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      pidx_q <= '0;
      pinv_q <= 1'b0;
    end else if (set_pend) begin
      pend_q <= 1'b1;
      pidx_q <= snp_index_i;
      pinv_q <= snp_inval_i;
    end else if (clr) begin
      pend_q <= 1'b0;
    end
  end

  // R3
  pend_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q && !clr |=> pend_q);
endmodule

// File: rtl/cache_flush_seq.sv
module cache_flush_seq
  import cfs_pkg::*;
#(
  parameter  int LINES = 8,
  localparam int IW    = $clog2(LINES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush_pin_i,
  input  logic          wbinv_cmd_i,
  input  logic          upd_valid_i,
  input  logic [IW-1:0] upd_index_i,
  input  logic [1:0]    upd_state_i,
  input  logic          snp_valid_i,
  input  logic [IW-1:0] snp_index_i,
  input  logic          snp_inval_i,
  output logic          snp_ready_o,
  output logic          snp_hitm_o,
  output logic          wb_req_o,
  output logic [IW-1:0] wb_index_o,
  output logic          wb_snoop_o,
  input  logic          wb_done_i,
  output logic          ack_req_o,
  output logic          ack_second_o,
  input  logic          ack_done_i,
  input  logic [IW-1:0] prb_index_i,
  output logic [1:0]    prb_state_o,
  output logic          busy_o
);
  function automatic logic [IW:0] step(input logic [IW:0] i);
    return i + 1'b1;
  endfunction

  function automatic logic any_mod(input line_st_t [LINES-1:0] l);
    logic r = 1'b0;
    for (int k = 0; k < LINES; k++) r |= (l[k] == LS_MOD);
    return r;
  endfunction

  fsm_t                 st_q, st_d;
  logic [IW:0]          idx_q, idx_d;
  logic                 busy_q, busy_d;
  line_st_t [LINES-1:0] lines;
  logic                 start, walk_end, walk_en;
  logic                 fire, hitm, kill_en, pend_q, pinv_q, in_flight, sw_en;
  logic [IW-1:0]        pidx_q, walk_idx;
  line_st_t             cur_st;

  assign walk_idx  = idx_q[IW-1:0];
  assign walk_end  = (idx_q == (IW+1)'(LINES));
  assign cur_st    = lines[walk_idx];
  assign start     = (flush_pin_i || wbinv_cmd_i) && !busy_q;
  assign in_flight = (st_q == F_CB) && (walk_idx == snp_index_i);
  assign sw_en     = (st_q == F_SWB) && wb_done_i;

  cfs_snoop #(.IW(IW)) u_snoop (
    .clk(clk), .rst_n(rst_n),
    .snp_valid_i(snp_valid_i), .snp_index_i(snp_index_i), .snp_inval_i(snp_inval_i),
    .hit_st(lines[snp_index_i]), .in_flight(in_flight),
    .swb_active(st_q == F_SWB), .clr(sw_en),
    .ready(snp_ready_o), .fire(fire), .hitm(hitm), .kill_en(kill_en),
    .pend_q(pend_q), .pidx_q(pidx_q), .pinv_q(pinv_q)
  );

  cfs_line_array #(.LINES(LINES), .IW(IW)) u_lines (
    .clk(clk), .rst_n(rst_n),
    .walk_en(walk_en), .walk_idx(walk_idx),
    .sw_en(sw_en), .sw_idx(pidx_q), .sw_st(after_snoop(pinv_q)),
    .kill_en(kill_en), .kill_idx(snp_index_i),
    .upd_en(upd_valid_i && !busy_q), .upd_idx(upd_index_i),
    .upd_st(line_st_t'(upd_state_i)),
    .lines_o(lines)
  );

  always_comb begin
    st_d    = st_q;
    idx_d   = idx_q;
    busy_d  = busy_q;
    walk_en = 1'b0;
    case (st_q)
      F_IDLE: begin
        if (pend_q)     st_d = F_SWB;
        else if (start) st_d = F_SCAN;
      end
      F_SCAN: begin
        if (pend_q) st_d = F_SWB;
        else if (!fire) begin
          if (walk_end)               st_d = F_ACK1;
          else if (cur_st == LS_MOD)  st_d = F_CB;
          else begin
            walk_en = 1'b1;
            idx_d   = step(idx_q);
          end
        end
      end
      F_CB: if (wb_done_i) begin
        walk_en = 1'b1;
        idx_d   = step(idx_q);
        st_d    = F_SCAN;
      end
      F_SWB:  if (wb_done_i) st_d = (busy_q || start) ? F_SCAN : F_IDLE;
      F_ACK1: if (ack_done_i) st_d = F_ACK2;
      F_ACK2: if (ack_done_i) begin
        st_d   = F_IDLE;
        busy_d = 1'b0;
      end
      default: st_d = F_IDLE;
    endcase
    if (start) begin
      busy_d = 1'b1;
      idx_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= F_IDLE;
      idx_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      busy_q <= busy_d;
    end
  end

  assign busy_o       = busy_q;
  assign snp_hitm_o   = hitm;
  assign wb_req_o     = (st_q == F_CB) || (st_q == F_SWB);
  assign wb_snoop_o   = (st_q == F_SWB);
  assign wb_index_o   = (st_q == F_SWB) ? pidx_q : walk_idx;
  assign ack_req_o    = (st_q == F_ACK1) || (st_q == F_ACK2);
  assign ack_second_o = (st_q == F_ACK2);
  assign prb_state_o  = lines[prb_index_i];

  // R1
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !(st_q == F_ACK2 && ack_done_i) |=> busy_q);
  // R2
  wb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_req_o && !wb_done_i |=> wb_req_o && $stable(wb_index_o) && $stable(wb_snoop_o));
  // R9
  ack_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_req_o |-> !any_mod(lines));
  // R7
  ack_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_second_o) |-> $past(ack_req_o));
  // R4
  idx_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> idx_q >= $past(idx_q));
endmodule

// File: tb/cache_flush_seq_bench.sv
`timescale 1ns/1ps
module cache_flush_seq_bench;
  localparam int LINES = 8;
  localparam int IW    = $clog2(LINES);

  logic clk = 1'b0, rst_n = 1'b0;
  logic flush_pin_i = 0, wbinv_cmd_i = 0, upd_valid_i = 0, snp_valid_i = 0, snp_inval_i = 0;
  logic [IW-1:0] upd_index_i = '0, snp_index_i = '0, prb_index_i = '0;
  logic [1:0] upd_state_i = '0, prb_state_o;
  logic wb_done_i = 0, ack_done_i = 0;
  logic snp_ready_o, snp_hitm_o, wb_req_o, wb_snoop_o, ack_req_o, ack_second_o, busy_o;
  logic [IW-1:0] wb_index_o;

  always #2 clk = ~clk;

  cache_flush_seq #(.LINES(LINES)) u_cache_flush_seq (.*);

  int compared = 0, mismatched = 0, cyc = 0;
  // reference model state
  int m_st = 0, m_idx = 0, m_busy = 0, m_pend = 0, m_pidx = 0, m_pinv = 0;
  int m_ln[LINES];
  // observations
  int dut_wr[LINES];
  int wr_log[$];
  int a1_cnt = 0, a2_cnt = 0, wb_lat = 0, ack_lat = 0;

  task automatic cmp(string tag, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // behavioural model: 0 idle, 1 walking, 2 copy-back, 3 snoop write, 4 ack1, 5 ack2
  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_st = 0; m_idx = 0; m_busy = 0; m_pend = 0; m_pidx = 0; m_pinv = 0;
      foreach (m_ln[k]) m_ln[k] = 0;
    end else begin
      int nl[LINES];
      int nst, nidx, nbusy, npend, npidx, npinv, si;
      bit rdy, fire, start;
      if (wb_req_o && wb_done_i) begin
        dut_wr[wb_index_o]++;
        wr_log.push_back(int'(wb_index_o) + (wb_snoop_o ? 100 : 0));
      end
      if (ack_req_o && ack_done_i) begin
        if (ack_second_o) a2_cnt++; else a1_cnt++;
      end
      nl = m_ln; nst = m_st; nidx = m_idx; nbusy = m_busy;
      npend = m_pend; npidx = m_pidx; npinv = m_pinv;
      si    = int'(snp_index_i);
      rdy   = (m_pend == 0) && (m_st != 3);
      fire  = snp_valid_i && rdy;
      start = (flush_pin_i || wbinv_cmd_i) && (m_busy == 0);
      if (upd_valid_i && m_busy == 0) nl[upd_index_i] = int'(upd_state_i);
      if (fire) begin
        if (m_ln[si] == 2) begin
          if (!(m_st == 2 && m_idx == si)) begin
            npend = 1; npidx = si; npinv = int'(snp_inval_i);
          end
        end else if (snp_inval_i) nl[si] = 0;
      end
      case (m_st)
        0: if (m_pend != 0) nst = 3; else if (start) nst = 1;
        1: if (m_pend != 0) nst = 3;
           else if (!fire) begin
             if (m_idx == LINES) nst = 4;
             else if (m_ln[m_idx] == 2) nst = 2;
             else begin nl[m_idx] = 0; nidx = m_idx + 1; end
           end
        2: if (wb_done_i) begin nl[m_idx] = 0; nidx = m_idx + 1; nst = 1; end
        3: if (wb_done_i) begin
             nl[m_pidx] = (m_pinv != 0) ? 0 : 1; npend = 0;
             nst = (m_busy != 0 || start) ? 1 : 0;
           end
        4: if (ack_done_i) nst = 5;
        5: if (ack_done_i) begin nst = 0; nbusy = 0; end
        default: nst = 0;
      endcase
      if (start) begin nbusy = 1; nidx = 0; end
      m_ln = nl; m_st = nst; m_idx = nidx; m_busy = nbusy;
      m_pend = npend; m_pidx = npidx; m_pinv = npinv;
    end
    #1;
    if (rst_n) begin
      cmp("R1 busy", int'(busy_o), m_busy);
      cmp("R2 wb_req", int'(wb_req_o), int'(m_st == 2 || m_st == 3));
      if (wb_req_o) begin
        cmp("R2 wb_index", int'(wb_index_o), (m_st == 3) ? m_pidx : m_idx);
        cmp("R3 wb_snoop", int'(wb_snoop_o), int'(m_st == 3));
      end
      cmp("R3 snp_ready", int'(snp_ready_o), int'(m_pend == 0 && m_st != 3));
      cmp("R7 ack_req", int'(ack_req_o), int'(m_st == 4 || m_st == 5));
      cmp("R7 ack_second", int'(ack_second_o), int'(m_st == 5));
    end
    if (cyc == 150000) begin
      mismatched++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  // burst engine stand-in with random latency
  always @(negedge clk) begin
    if (wb_done_i) begin wb_done_i = 0; wb_lat = $urandom % 4; end
    else if (wb_req_o) begin if (wb_lat == 0) wb_done_i = 1; else wb_lat--; end
    if (ack_done_i) begin ack_done_i = 0; ack_lat = $urandom % 4; end
    else if (ack_req_o) begin if (ack_lat == 0) ack_done_i = 1; else ack_lat--; end
  end

  task automatic upd(int i, int s);
    @(negedge clk); upd_valid_i = 1; upd_index_i = IW'(i); upd_state_i = 2'(s);
    @(negedge clk); upd_valid_i = 0;
  endtask

  task automatic probe(string tag, int i, int exp);
    prb_index_i = IW'(i); #0.5;
    cmp(tag, int'(prb_state_o), exp);
  endtask

  task automatic snoop(int i, int inv, output int hit);
    @(negedge clk); snp_valid_i = 1; snp_index_i = IW'(i); snp_inval_i = inv[0];
    #0.5; hit = int'(snp_hitm_o);
    @(negedge clk); snp_valid_i = 0;
  endtask

  task automatic settle();
    for (int k = 0; k < 20; k++) @(negedge clk);
  endtask

  task automatic clear_obs();
    foreach (dut_wr[k]) dut_wr[k] = 0;
    wr_log.delete(); a1_cnt = 0; a2_cnt = 0;
  endtask

  // flush with random snoops and ignored repeat requests
  task automatic flush_run(bit use_pin, int rate);
    int was_mod[LINES];
    foreach (was_mod[k]) was_mod[k] = (m_ln[k] == 2);
    clear_obs();
    @(negedge clk);
    if (use_pin) flush_pin_i = 1; else wbinv_cmd_i = 1;
    @(negedge clk); flush_pin_i = 0; wbinv_cmd_i = 0;
    while (busy_o) begin
      snp_valid_i = ($urandom % rate) == 0;
      snp_index_i = IW'($urandom % LINES);
      snp_inval_i = $urandom % 2;
      flush_pin_i = ($urandom % 9) == 0;   // R8: ignored while busy
      wbinv_cmd_i = ($urandom % 9) == 0;
      @(negedge clk);
    end
    snp_valid_i = 0; flush_pin_i = 0; wbinv_cmd_i = 0;
    settle();
    for (int k = 0; k < LINES; k++) begin
      cmp("R9 writes per line", dut_wr[k], was_mod[k]);
      probe("R9 line invalid", k, 0);
    end
    cmp("R7 first ack count", a1_cnt, 1);
    cmp("R7 second ack count", a2_cnt, 1);
  endtask

  initial begin
    int h;
    clear_obs();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10 reset state
    cmp("R10 busy", int'(busy_o), 0);
    cmp("R10 wb_req", int'(wb_req_o), 0);
    cmp("R10 ack_req", int'(ack_req_o), 0);
    cmp("R10 snp_ready", int'(snp_ready_o), 1);
    for (int k = 0; k < LINES; k++) probe("R10 line", k, 0);

    // R11 preload: M C I M M C I M
    upd(0, 2); upd(1, 1); upd(2, 0); upd(3, 2);
    upd(4, 2); upd(5, 1); upd(6, 0); upd(7, 2);
    probe("R11 line0", 0, 2); probe("R11 line1", 1, 1);
    probe("R11 line2", 2, 0); probe("R11 line7", 7, 2);

    // R3 / R6 snoops outside a flush
    clear_obs();
    snoop(3, 0, h); cmp("R3 hitm on modified", h, 1);
    settle();
    probe("R3 line3 clean after write", 3, 1);
    cmp("R3 snoop write count", dut_wr[3], 1);
    cmp("R3 snoop write flagged", (wr_log.size() > 0) ? wr_log[0] : -1, 103);
    snoop(1, 1, h); cmp("R6 hitm on clean", h, 0);
    settle();
    probe("R6 clean invalidated", 1, 0);
    snoop(5, 0, h); settle();
    probe("R6 clean unchanged", 5, 1);
    cmp("R6 no bus write line1", dut_wr[1], 0);
    cmp("R6 no bus write line5", dut_wr[5], 0);
    upd(3, 2);

    // R1 R2 R8 R9 flush by pin
    flush_run(1'b1, 3);

    // R4 R5 directed: lines 2,5,6 modified
    upd(2, 2); upd(5, 2); upd(6, 2);
    clear_obs();
    @(negedge clk); wbinv_cmd_i = 1;
    @(negedge clk); wbinv_cmd_i = 0;
    while (!(wb_req_o && wb_index_o == IW'(2) && !wb_snoop_o)) @(negedge clk);
    snp_valid_i = 1; snp_index_i = IW'(2); snp_inval_i = 1;
    #0.5; cmp("R5 hitm on in-flight line", int'(snp_hitm_o), 1);
    @(negedge clk); snp_valid_i = 0;
    snoop(5, 0, h); cmp("R3 hitm ahead of walk", h, 1);
    upd(7, 2);                                 // R8: ignored while busy
    while (busy_o) @(negedge clk);
    settle();
    cmp("R5 single write line2", dut_wr[2], 1);
    cmp("R4 write order size", wr_log.size(), 3);
    if (wr_log.size() == 3) begin
      cmp("R2 first write walk line2", wr_log[0], 2);
      cmp("R3 snoop write line5", wr_log[1], 105);
      cmp("R4 resumed walk line6", wr_log[2], 6);
    end
    cmp("R8 update ignored no write", dut_wr[7], 0);
    probe("R8 update ignored line7", 7, 0);

    // random rounds
    for (int r = 0; r < 8; r++) begin
      for (int k = 0; k < LINES; k++) upd(k, $urandom % 3);
      flush_run(r[0], 2 + (r % 4));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule